// File: doc/BRIEF.md
# Branch Rename Checkpoint Buffer

This block keeps copies of the register rename map taken at conditional and indirect branches. Each time the rename stage handles such a branch, it presents the current map together with the branch's sequence tag. The block saves both in a circular buffer and returns the slot index it used. Later, the execution side reports branch outcomes by that index.

A wrong prediction does not wait for the branch to become the oldest operation in flight. One clock after the report, the saved map comes out for the rename table to reload, along with a flush strobe carrying the branch's sequence tag. Everything younger than that tag must be discarded. Checkpoints of older branches stay live, so older work keeps running and can still recover later.

Two resolve ports can report in the same clock. If several reports are wrong predictions, the oldest one is acted on. The retire side frees checkpoints in order, oldest first. When every slot is in use, the block raises a full flag so that branch rename stalls.

Top module: `ckpt_recovery_buf`

## Requirements
- R1: When allocValid is high, full is low and no resolve port reports an accepted mispredict, the map and sequence tag are stored in slot allocIdx, and allocIdx advances by one (modulo DEPTH) on the next clock.
- R2: full is high exactly when DEPTH checkpoints are live. While full is high, allocValid has no effect: allocIdx holds and no slot is written.
- R3: retireValid frees the oldest live checkpoint. When the buffer is empty it has no effect, and later fills still reach full only after DEPTH allocations.
- R4: A mispredict on a live, not yet resolved slot sets rcvValid high on the next clock. In that same cycle rcvMap and rcvSeq show the map and sequence tag stored for that slot.
- R5: After an accepted mispredict on slot i, every checkpoint younger than i is freed in that one clock (allocIdx becomes i+1 modulo DEPTH). Slot i and all older checkpoints stay live and can still recover.
- R6: An allocation requested in the same clock as an accepted mispredict is dropped.
- R7: A resolve naming a slot that is not live has no effect: there is no rcvValid and allocIdx does not change.
- R8: When both resolve ports report mispredicts in one clock, the checkpoint older in buffer order wins. Port number gives no priority.
- R9: A correct resolve marks its slot as done, and a later mispredict on that slot is ignored. A correct resolve for a slot younger than a same-clock accepted mispredict is ignored.
- R10: After reset the buffer is empty: allocIdx is 0, full is 0 and rcvValid is 0.
- R11: Slot indices wrap modulo DEPTH. Age order and liveness are taken relative to the oldest live slot, so they stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | A branch is being renamed and wants a checkpoint |
| allocMap | input | ARCH_REGS*PREG_W | Current rename map, one PREG_W field per architectural register |
| allocSeq | input | SEQ_W | Sequence tag of the branch |
| allocIdx | output | log2(DEPTH) | Slot given to the branch being allocated |
| full | output | 1 | All slots live; branch rename must stall |
| resValid | input | RES_PORTS | One valid bit per resolve port |
| resMis | input | RES_PORTS | Per port: 1 = mispredicted, 0 = correct |
| resIdx | input | RES_PORTS*log2(DEPTH) | Per port slot index; port p uses bits [p*log2(DEPTH) +: log2(DEPTH)] |
| retireValid | input | 1 | Free the oldest checkpoint |
| rcvValid | output | 1 | Recovery strobe: restore the map and flush everything younger than rcvSeq |
| rcvMap | output | ARCH_REGS*PREG_W | Saved map to restore |
| rcvSeq | output | SEQ_W | Sequence tag of the mispredicted branch (flush boundary) |

## Verification
The slot pointer and the full flag are registered, so their response to an allocate, retire or resolve is due one clock after the edge that samples it. The recovery strobe, map and tag are likewise due exactly one clock after the mispredict report. The bench drives inputs just after an edge and advances a behavioural queue model of live checkpoints for that edge. It then compares allocIdx, full, rcvValid and, when a recovery is due, rcvMap and rcvSeq, two nanoseconds after the next rising edge. Directed phases cover each ordering and boundary, and a long random phase then mixes every kind of input.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  // Strobes from control to storage
  typedef struct packed {
    logic save;    // write allocMap/allocSeq into wrIdx
    logic recall;  // read slot rdIdx onto the recovery outputs
  } ckptStrobe_t;
endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl #(
  parameter int DEPTH     = 128,
  parameter int RES_PORTS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          allocValid,
  input  logic                          retireValid,
  input  logic [RES_PORTS-1:0]          resValid,
  input  logic [RES_PORTS-1:0]          resMis,
  input  logic [RES_PORTS*$clog2(DEPTH)-1:0] resIdx,
  output logic [$clog2(DEPTH)-1:0]      allocIdx,
  output logic                          full,
  output ckpt_pkg::ckptStrobe_t         strobe,
  output logic [$clog2(DEPTH)-1:0]      wrIdx,
  output logic [$clog2(DEPTH)-1:0]      rdIdx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int POS_W = IDX_W + 1;

  logic [POS_W-1:0] headPos, tailPos, liveCnt;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [DEPTH-1:0] doneBits;

  assign headIdx = headPos[IDX_W-1:0];
  assign tailIdx = tailPos[IDX_W-1:0];
  assign liveCnt = tailPos - headPos;
  assign full    = (liveCnt == POS_W'(DEPTH));

  logic [IDX_W-1:0] portIdx [RES_PORTS];
  logic [IDX_W-1:0] portOff [RES_PORTS];
  logic [RES_PORTS-1:0] portBad, portGood;

  for (genvar p = 0; p < RES_PORTS; p++) begin : g_port
    logic portLive;
    assign portIdx[p] = resIdx[p*IDX_W +: IDX_W];
    assign portOff[p] = portIdx[p] - headIdx;          // age relative to oldest
    assign portLive   = ({1'b0, portOff[p]} < liveCnt);
    assign portBad[p]  = resValid[p] & resMis[p] & portLive & ~doneBits[portIdx[p]];
    assign portGood[p] = resValid[p] & ~resMis[p] & portLive;
  end

  // Oldest accepted mispredict wins
  logic             misHit;
  logic [IDX_W-1:0] misOff, misIdx;
  always_comb begin
    misHit = 1'b0;
    misOff = '0;
    misIdx = '0;
    for (int p = 0; p < RES_PORTS; p++) begin
      if (portBad[p] && (!misHit || portOff[p] < misOff)) begin
        misHit = 1'b1;
        misOff = portOff[p];
        misIdx = portIdx[p];
      end
    end
  end

  logic doAlloc, doRet;
  assign doAlloc = allocValid & ~full & ~misHit;
  assign doRet   = retireValid & (liveCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPos <= '0;
      tailPos <= '0;
    end else begin
      headPos <= headPos + POS_W'(doRet);
      if (misHit)
        tailPos <= headPos + {1'b0, misOff} + POS_W'(1);
      else if (doAlloc)
        tailPos <= tailPos + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneBits <= '0;
    end else begin
      if (doAlloc) doneBits[tailIdx] <= 1'b0;
      for (int p = 0; p < RES_PORTS; p++) begin
        if (portGood[p] && (!misHit || portOff[p] < misOff))
          doneBits[portIdx[p]] <= 1'b1;
      end
    end
  end

  assign strobe.save   = doAlloc;
  assign strobe.recall = misHit;
  assign wrIdx    = tailIdx;
  assign rdIdx    = misIdx;
  assign allocIdx = tailIdx;
endmodule

// File: rtl/ckpt_store.sv
module ckpt_store #(
  parameter int DEPTH = 128,
  parameter int MAP_W = 56,
  parameter int SEQ_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ckpt_pkg::ckptStrobe_t    strobe,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  input  logic [MAP_W-1:0]         wrMap,
  input  logic [SEQ_W-1:0]         wrSeq,
  output logic                     rcvValid,
  output logic [MAP_W-1:0]         rcvMap,
  output logic [SEQ_W-1:0]         rcvSeq
);
  logic [MAP_W-1:0] mapMem [DEPTH];
  logic [SEQ_W-1:0] seqMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.save) begin
      mapMem[wrIdx] <= wrMap;
      seqMem[wrIdx] <= wrSeq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcvValid <= 1'b0;
      rcvMap   <= '0;
      rcvSeq   <= '0;
    end else begin
      rcvValid <= strobe.recall;
      if (strobe.recall) begin
        rcvMap <= mapMem[rdIdx];
        rcvSeq <= seqMem[rdIdx];
      end
    end
  end
endmodule

// File: rtl/ckpt_recovery_buf.sv
module ckpt_recovery_buf #(
  parameter int DEPTH     = 128,
  parameter int ARCH_REGS = 8,
  parameter int PREG_W    = 7,
  parameter int SEQ_W     = 10,
  parameter int RES_PORTS = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                allocValid,
  input  logic [ARCH_REGS*PREG_W-1:0]         allocMap,
  input  logic [SEQ_W-1:0]                    allocSeq,
  output logic [$clog2(DEPTH)-1:0]            allocIdx,
  output logic                                full,
  input  logic [RES_PORTS-1:0]                resValid,
  input  logic [RES_PORTS-1:0]                resMis,
  input  logic [RES_PORTS*$clog2(DEPTH)-1:0]  resIdx,
  input  logic                                retireValid,
  output logic                                rcvValid,
  output logic [ARCH_REGS*PREG_W-1:0]         rcvMap,
  output logic [SEQ_W-1:0]                    rcvSeq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int MAP_W = ARCH_REGS * PREG_W;

  ckpt_pkg::ckptStrobe_t strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  ckpt_ctrl #(.DEPTH(DEPTH), .RES_PORTS(RES_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .retireValid(retireValid),
    .resValid(resValid), .resMis(resMis), .resIdx(resIdx),
    .allocIdx(allocIdx), .full(full), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  ckpt_store #(.DEPTH(DEPTH), .MAP_W(MAP_W), .SEQ_W(SEQ_W)) u_store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrMap(allocMap), .wrSeq(allocSeq),
    .rcvValid(rcvValid), .rcvMap(rcvMap), .rcvSeq(rcvSeq)
  );
endmodule

// File: rtl/ckpt_recovery_chk.sv
module ckpt_recovery_chk #(
  parameter int DEPTH     = 128,
  parameter int RES_PORTS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     allocValid,
  input logic                     full,
  input logic [$clog2(DEPTH)-1:0] allocIdx,
  input logic [RES_PORTS-1:0]     resValid,
  input logic [RES_PORTS-1:0]     resMis,
  input logic                     retireValid,
  input logic                     rcvValid,
  input logic [$clog2(DEPTH)-1:0] rdIdx
);
  localparam int IDX_W = $clog2(DEPTH);

  // R4
  rcv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcvValid |-> $past(|(resValid & resMis)));

  // R5
  flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcvValid |-> allocIdx == IDX_W'($past(rdIdx) + IDX_W'(1)));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !retireValid && !(|(resValid & resMis))) |=> full);

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && allocValid && !(|(resValid & resMis))) |=> $stable(allocIdx));

  // R1
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allocValid && !full && !(|(resValid & resMis))) |=> allocIdx == IDX_W'($past(allocIdx) + IDX_W'(1)));
endmodule

bind ckpt_recovery_buf ckpt_recovery_chk #(.DEPTH(DEPTH), .RES_PORTS(RES_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .full(full), .allocIdx(allocIdx),
  .resValid(resValid), .resMis(resMis), .retireValid(retireValid),
  .rcvValid(rcvValid), .rdIdx(rdIdx)
);

// File: tb/ckpt_recovery_buf_bench.sv
module ckpt_recovery_buf_bench;
  localparam int DEPTH = 128, ARCH_REGS = 8, PREG_W = 7, SEQ_W = 10, RES_PORTS = 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int MAP_W = ARCH_REGS * PREG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allocValid = 1'b0;
  logic [MAP_W-1:0] allocMap = '0;
  logic [SEQ_W-1:0] allocSeq = '0;
  logic [IDX_W-1:0] allocIdx;
  logic full;
  logic [RES_PORTS-1:0] resValid = '0;
  logic [RES_PORTS-1:0] resMis = '0;
  logic [RES_PORTS*IDX_W-1:0] resIdx = '0;
  logic retireValid = 1'b0;
  logic rcvValid;
  logic [MAP_W-1:0] rcvMap;
  logic [SEQ_W-1:0] rcvSeq;

  always #4 clk = ~clk;

  ckpt_recovery_buf #(.DEPTH(DEPTH), .ARCH_REGS(ARCH_REGS), .PREG_W(PREG_W),
                      .SEQ_W(SEQ_W), .RES_PORTS(RES_PORTS)) u_ckpt_recovery_buf (
    .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .allocMap(allocMap),
    .allocSeq(allocSeq), .allocIdx(allocIdx), .full(full), .resValid(resValid),
    .resMis(resMis), .resIdx(resIdx), .retireValid(retireValid),
    .rcvValid(rcvValid), .rcvMap(rcvMap), .rcvSeq(rcvSeq)
  );

  // Behavioural model: queue of live checkpoints, oldest first
  int mIdx[$];
  logic [MAP_W-1:0] mMap[$];
  logic [SEQ_W-1:0] mSeq[$];
  bit mDone[$];
  int mTail = 0;
  int checks = 0, errors = 0;
  string req = "R10";
  logic [SEQ_W-1:0] seqCtr = '0;
  bit finished = 0;

  function automatic int findPos(int idx);
    foreach (mIdx[i]) if (mIdx[i] == idx) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int winPos, sz0, pos;
    bit retOk, expRcv;
    logic [MAP_W-1:0] expMap;
    logic [SEQ_W-1:0] expSeq;
    sz0 = mIdx.size();
    retOk = retireValid && sz0 > 0;
    winPos = -1;
    expMap = '0;
    expSeq = '0;
    for (int p = 0; p < RES_PORTS; p++) begin
      if (resValid[p] && resMis[p]) begin
        pos = findPos(int'(resIdx[p*IDX_W +: IDX_W]));
        if (pos >= 0 && !mDone[pos] && (winPos < 0 || pos < winPos)) winPos = pos;
      end
    end
    for (int p = 0; p < RES_PORTS; p++) begin
      if (resValid[p] && !resMis[p]) begin
        pos = findPos(int'(resIdx[p*IDX_W +: IDX_W]));
        if (pos >= 0 && (winPos < 0 || pos < winPos)) mDone[pos] = 1;
      end
    end
    expRcv = (winPos >= 0);
    if (expRcv) begin
      expMap = mMap[winPos];
      expSeq = mSeq[winPos];
      mTail = (mIdx[winPos] + 1) % DEPTH;
      while (mIdx.size() > winPos + 1) begin
        void'(mIdx.pop_back()); void'(mMap.pop_back());
        void'(mSeq.pop_back()); void'(mDone.pop_back());
      end
    end else if (allocValid && sz0 < DEPTH) begin
      mIdx.push_back(mTail); mMap.push_back(allocMap);
      mSeq.push_back(allocSeq); mDone.push_back(1'b0);
      mTail = (mTail + 1) % DEPTH;
    end
    if (retOk) begin
      void'(mIdx.pop_front()); void'(mMap.pop_front());
      void'(mSeq.pop_front()); void'(mDone.pop_front());
    end
    @(posedge clk); #2;
    chk(int'(allocIdx) == mTail, "allocIdx", 64'(allocIdx), 64'(mTail));
    chk(full == (mIdx.size() == DEPTH), "full", 64'(full), 64'(mIdx.size() == DEPTH));
    chk(rcvValid == expRcv, "rcvValid", 64'(rcvValid), 64'(expRcv));
    if (expRcv) begin
      chk(rcvMap == expMap, "rcvMap", 64'(rcvMap), 64'(expMap));
      chk(rcvSeq == expSeq, "rcvSeq", 64'(rcvSeq), 64'(expSeq));
    end
    allocValid = 1'b0; resValid = '0; resMis = '0; retireValid = 1'b0;
  endtask

  task automatic setAlloc();
    allocValid = 1'b1;
    allocMap = MAP_W'({$urandom, $urandom});
    allocSeq = seqCtr;
    seqCtr = seqCtr + 1'b1;
  endtask

  task automatic setRes(int p, int idx, bit mis);
    resValid[p] = 1'b1;
    resMis[p] = mis;
    resIdx[p*IDX_W +: IDX_W] = IDX_W'(idx);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    req = "R10"; step();
    req = "R1";  for (int i = 0; i < 5; i++) begin setAlloc(); step(); end
    // R4 + R6: mispredict slot 2 with a same-clock allocation
    req = "R4";  setRes(0, 2, 1'b1); setAlloc(); step();
    req = "R5";  setRes(1, 1, 1'b1); step();          // older slot still recovers
    req = "R7";  setRes(0, 3, 1'b1); step();          // slot 3 is freed
    req = "R7";  setRes(1, 100, 1'b0); setRes(0, 90, 1'b1); step();
    req = "R9";  setAlloc(); step();                  // slot 2
    req = "R9";  setRes(1, 1, 1'b0); step();
    req = "R9";  setRes(0, 1, 1'b1); step();          // ignored: already correct
    req = "R9";  setRes(0, 0, 1'b1); setRes(1, 2, 1'b0); step();
    req = "R9";  setAlloc(); step(); setAlloc(); step();
    req = "R9";  setRes(0, 2, 1'b1); step();          // stale mark must not block
    req = "R8";  for (int i = 0; i < 3; i++) begin setAlloc(); step(); end
    req = "R8";  setRes(0, 5, 1'b1); setRes(1, 3, 1'b1); step();
    req = "R3";  for (int i = 0; i < 8; i++) begin retireValid = 1'b1; step(); end
    req = "R3";  retireValid = 1'b1; setAlloc(); step();   // empty: retire ignored
    req = "R2";  for (int i = 0; i < DEPTH + 3; i++) begin setAlloc(); step(); end
    req = "R2";  setAlloc(); retireValid = 1'b1; step();
    req = "R11"; for (int i = 0; i < 3; i++) begin retireValid = 1'b1; step(); end
    req = "R11"; for (int i = 0; i < 4; i++) begin setAlloc(); step(); end
    req = "R11"; setRes(0, mIdx[mIdx.size()-1], 1'b1); setRes(1, mIdx[5], 1'b1); step();
    req = "R11";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 4 != 0) setAlloc();
      if ($urandom % 3 == 0) retireValid = 1'b1;
      for (int p = 0; p < RES_PORTS; p++) begin
        if ($urandom % 10 == 0) begin
          if (mIdx.size() > 0 && $urandom % 4 != 0)
            setRes(p, mIdx[$urandom % mIdx.size()], ($urandom % 4 == 0));
          else
            setRes(p, int'($urandom % DEPTH), ($urandom % 2 == 0));
        end
      end
      step();
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule